// File: doc/BRIEF.md
# Binary64 Floating-Point Compare Unit

This block compares two IEEE-754 double-precision operands for the scalar half of a vector-scalar execution path. It reports the result as a one-hot four-bit condition code with separate bits for less, greater, equal and unordered. The same code goes to two places: the result-class field of the floating-point status register, where it replaces the previous contents, and one of eight condition-register fields chosen by a three-bit target index. The unit also raises two invalid-operation flags. One is for signaling-NaN inputs. The other is an invalid-compare flag that only ordered compares raise.

The operands, mode bit and target index are sampled on a clock edge when `inValid` is high. All results appear one cycle later. The condition-register write strobe is high for exactly that one cycle and carries the captured index. The exception flags are high only in the same cycle; making them sticky and delivering traps belongs to logic outside this unit. The instruction decoder sets `orderedMode` to 1 for the ordered variant (extended opcode 0x05) and to 0 for the unordered variant (extended opcode 0x04).

Top module: `fcmp_unit`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the captured condition code is 4'b0001 (unordered), whatever the magnitudes or signs.
- R2: With no NaN present and A below B, the condition code is 4'b1000.
- R3: With no NaN present and A above B, the condition code is 4'b0100.
- R4: With no NaN present and A equal to B, the condition code is 4'b0010; +0 and -0 are equal.
- R5: `flagSnan` is 1 in the result cycle when either operand is a signaling NaN (fraction bit 51 clear), in both modes; a quiet NaN (bit 51 set) alone does not raise it.
- R6: `flagInvCmp` is 1 in the result cycle when any NaN is present and `orderedMode` was 1; with `orderedMode` 0 it stays 0.
- R7: `resultClass` takes the new condition code one cycle after a captured operation, and keeps its value (as does `condCode`) while `inValid` is low.
- R8: `crWriteEn` is high in exactly the cycle after each captured operation, with `crWriteIdx` equal to the captured `targetField`; back-to-back operations give consecutive strobes, each with its own index.
- R9: Infinities are ordered: -inf is below every finite value, +inf is above every finite value, and equal-signed infinities compare equal.
- R10: With no NaN present, when the signs differ the negative operand is the smaller one; when both are negative, the larger magnitude is the smaller value.
- R11: Subnormal operands are compared exactly, with no flush to zero; the smallest positive subnormal is above +0.
- R12: After reset, `condCode`, `resultClass`, `crWriteEn`, `crWriteIdx` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Capture strobe for one compare operation |
| orderedMode | input | 1 | 1 = ordered compare, 0 = unordered compare |
| targetField | input | 3 | Index of the condition-register field to write |
| opA | input | 64 | Binary64 operand A |
| opB | input | 64 | Binary64 operand B |
| condCode | output | 4 | One-hot code {lt, gt, eq, un} for the condition register |
| resultClass | output | 4 | Updated result-class field of the status register |
| crWriteEn | output | 1 | One-cycle condition-register field write strobe |
| crWriteIdx | output | 3 | Field index that goes with `crWriteEn` |
| flagSnan | output | 1 | Invalid operation: signaling NaN operand |
| flagInvCmp | output | 1 | Invalid operation: ordered compare with a NaN |

## Verification
The bench targets the sign-magnitude traps. With ±0, a plain bit compare would call the two values unequal. With two negative operands, a design that forgets to reverse the order swaps less and greater. Operands with bit 51 set or clear separate quiet from signaling NaNs: a wrong quiet-bit test shows up as a missing or spurious `flagSnan`, and a mode mix-up shows up as `flagInvCmp` in unordered mode. Subnormal and infinity pairs would expose a flush to zero or a wrongly special-cased exponent. Quiet cycles with changing operands would expose a result field or write strobe that does not hold.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam logic [3:0] CC_LT = 4'b1000;
  localparam logic [3:0] CC_GT = 4'b0100;
  localparam logic [3:0] CC_EQ = 4'b0010;
  localparam logic [3:0] CC_UN = 4'b0001;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic ordered;
  } ctrl_strobe_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int DATA_W = 64,
  parameter int EXP_W  = 11
) (
  input  logic [DATA_W-1:0] operand,
  output logic              isNan,
  output logic              isSnan,
  output logic              isZero,
  output logic              sign,
  output logic [DATA_W-2:0] mag
);
  localparam int FRAC_W = DATA_W - 1 - EXP_W;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;

  always_comb begin
    expField  = operand[DATA_W-2 -: EXP_W];
    fracField = operand[FRAC_W-1:0];
    sign      = operand[DATA_W-1];
    mag       = operand[DATA_W-2:0];
    isNan     = (&expField) && (|fracField);
    isSnan    = isNan && !fracField[FRAC_W-1];
    isZero    = ~|operand[DATA_W-2:0];
  end
endmodule

// File: rtl/fcmp_control.sv
module fcmp_control
  import fcmp_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             orderedMode,
  input  logic [IDX_W-1:0] targetField,
  output ctrl_strobe_t     strb,
  output logic             crWriteEn,
  output logic [IDX_W-1:0] crWriteIdx
);
  always_comb begin
    strb.capture = inValid;
    strb.ordered = orderedMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crWriteEn  <= 1'b0;
      crWriteIdx <= '0;
    end else begin
      crWriteEn <= inValid;
      if (inValid) crWriteIdx <= targetField;
    end
  end

  // R8: the index only changes when a new write is being strobed
  p_idx_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !crWriteEn |-> $stable(crWriteIdx) || $past(!rstN));
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EXP_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [3:0]        condCode,
  output logic [3:0]        resultClass,
  output logic              flagSnan,
  output logic              flagInvCmp
);
  localparam int NUM_OPS = 2;

  logic [DATA_W-1:0] opVec   [NUM_OPS];
  logic              nanV    [NUM_OPS];
  logic              snanV   [NUM_OPS];
  logic              zeroV   [NUM_OPS];
  logic              signV   [NUM_OPS];
  logic [DATA_W-2:0] magV    [NUM_OPS];

  assign opVec[0] = opA;
  assign opVec[1] = opB;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    fcmp_classify #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cls (
      .operand (opVec[g]),
      .isNan   (nanV[g]),
      .isSnan  (snanV[g]),
      .isZero  (zeroV[g]),
      .sign    (signV[g]),
      .mag     (magV[g])
    );
  end

  logic       anyNan, anySnan, isLess, isGreater, magLess;
  logic [3:0] nextCc;

  always_comb begin
    anyNan    = nanV[0] | nanV[1];
    anySnan   = snanV[0] | snanV[1];
    magLess   = magV[0] < magV[1];
    isLess    = 1'b0;
    isGreater = 1'b0;
    if (zeroV[0] && zeroV[1]) begin
      isLess    = 1'b0;
      isGreater = 1'b0;
    end else if (signV[0] != signV[1]) begin
      isLess    = signV[0];
      isGreater = signV[1];
    end else if (magV[0] != magV[1]) begin
      isLess    = signV[0] ? !magLess : magLess;
      isGreater = !isLess;
    end
    if (anyNan)         nextCc = CC_UN;
    else if (isLess)    nextCc = CC_LT;
    else if (isGreater) nextCc = CC_GT;
    else                nextCc = CC_EQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condCode    <= '0;
      resultClass <= '0;
      flagSnan    <= 1'b0;
      flagInvCmp  <= 1'b0;
    end else begin
      flagSnan   <= strb.capture && anySnan;
      flagInvCmp <= strb.capture && anyNan && strb.ordered;
      if (strb.capture) begin
        condCode    <= nextCc;
        resultClass <= nextCc;
      end
    end
  end

  // R1: a NaN input always yields the unordered code
  p_nan_unordered_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && anyNan |=> condCode == CC_UN);

  // R5: signaling flag only accompanies an unordered result
  p_snan_unordered_r5: assert property (@(posedge clk) disable iff (!rstN)
    flagSnan |-> condCode == CC_UN);

  // R6: invalid-compare flag only with an unordered result
  p_invcmp_unordered_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagInvCmp |-> condCode == CC_UN);

  // R7: status field keeps its value without a capture
  p_class_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(resultClass));
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EXP_W  = 11,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              orderedMode,
  input  logic [IDX_W-1:0]  targetField,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [3:0]        condCode,
  output logic [3:0]        resultClass,
  output logic              crWriteEn,
  output logic [IDX_W-1:0]  crWriteIdx,
  output logic              flagSnan,
  output logic              flagInvCmp
);
  ctrl_strobe_t strb;

  fcmp_control #(.IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .orderedMode (orderedMode),
    .targetField (targetField),
    .strb        (strb),
    .crWriteEn   (crWriteEn),
    .crWriteIdx  (crWriteIdx)
  );

  fcmp_datapath #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .opA         (opA),
    .opB         (opB),
    .condCode    (condCode),
    .resultClass (resultClass),
    .flagSnan    (flagSnan),
    .flagInvCmp  (flagInvCmp)
  );

  // R6: the invalid-compare flag needs an ordered request one cycle earlier
  p_invcmp_mode_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagInvCmp |-> $past(orderedMode && inValid));

  // R8: the strobe carries the index presented with the request
  p_idx_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    crWriteEn |-> crWriteIdx == $past(targetField));

  // R7: after a write both copies of the code agree and are one-hot
  p_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    crWriteEn |-> $onehot(condCode) && resultClass == condCode);
endmodule

// File: tb/fcmp_unit_tb.sv
module fcmp_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        orderedMode = 1'b0;
  logic [2:0]  targetField = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [3:0]  condCode, resultClass;
  logic        crWriteEn, flagSnan, flagInvCmp;
  logic [2:0]  crWriteIdx;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  fcmp_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .orderedMode(orderedMode),
    .targetField(targetField), .opA(opA), .opB(opB), .condCode(condCode),
    .resultClass(resultClass), .crWriteEn(crWriteEn), .crWriteIdx(crWriteIdx),
    .flagSnan(flagSnan), .flagInvCmp(flagInvCmp)
  );

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] PMAX = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] NMAX = 64'hFFEFFFFFFFFFFFFF;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] NQNAN= 64'hFFF8000000000001;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] SUB1 = 64'h0000000000000001;
  localparam logic [63:0] SUB2 = 64'h0000000000000002;
  localparam logic [63:0] NSUB = 64'h800FFFFFFFFFFFFF;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        ord;
    logic [3:0]  cc;
    logic        sn;
    logic        ic;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{P1,   P2,   1'b0, 4'b1000, 1'b0, 1'b0, 8'd2},   // R2
    '{P2,   P1,   1'b1, 4'b0100, 1'b0, 1'b0, 8'd3},   // R3
    '{P1,   P1,   1'b0, 4'b0010, 1'b0, 1'b0, 8'd4},   // R4
    '{PZ,   NZ,   1'b1, 4'b0010, 1'b0, 1'b0, 8'd4},   // R4 signed zeros
    '{NZ,   PZ,   1'b0, 4'b0010, 1'b0, 1'b0, 8'd4},   // R4
    '{N2,   N1,   1'b0, 4'b1000, 1'b0, 1'b0, 8'd10},  // R10 both negative
    '{N1,   N2,   1'b0, 4'b0100, 1'b0, 1'b0, 8'd10},  // R10
    '{N1,   P1,   1'b0, 4'b1000, 1'b0, 1'b0, 8'd10},  // R10 sign differs
    '{P1,   NZ,   1'b0, 4'b0100, 1'b0, 1'b0, 8'd10},  // R10
    '{NINF, NMAX, 1'b0, 4'b1000, 1'b0, 1'b0, 8'd9},   // R9
    '{PINF, PMAX, 1'b1, 4'b0100, 1'b0, 1'b0, 8'd9},   // R9
    '{NINF, NINF, 1'b0, 4'b0010, 1'b0, 1'b0, 8'd9},   // R9
    '{SUB1, SUB2, 1'b0, 4'b1000, 1'b0, 1'b0, 8'd11},  // R11
    '{SUB1, PZ,   1'b0, 4'b0100, 1'b0, 1'b0, 8'd11},  // R11
    '{NSUB, NZ,   1'b0, 4'b1000, 1'b0, 1'b0, 8'd11},  // R11
    '{QNAN, P1,   1'b0, 4'b0001, 1'b0, 1'b0, 8'd1},   // R1
    '{P1,   NQNAN,1'b1, 4'b0001, 1'b0, 1'b1, 8'd6},   // R6 ordered quiet
    '{P1,   SNAN, 1'b0, 4'b0001, 1'b1, 1'b0, 8'd5},   // R5 unordered
    '{SNAN, QNAN, 1'b1, 4'b0001, 1'b1, 1'b1, 8'd5},   // R5 ordered
    '{PINF, QNAN, 1'b0, 4'b0001, 1'b0, 1'b0, 8'd1}    // R1
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge; result sampled at the next falling edge
  task automatic issue(input logic [63:0] a, input logic [63:0] b,
                       input logic ord, input logic [2:0] idx);
    opA = a; opB = b; orderedMode = ord; targetField = idx; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(condCode == 0 && resultClass == 0, "R12 codes", {condCode, resultClass}, 0);
    check(!crWriteEn && crWriteIdx == 0, "R12 strobe", {crWriteEn, crWriteIdx}, 0);
    check(!flagSnan && !flagInvCmp, "R12 flags", {flagSnan, flagInvCmp}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].a, VECS[i].b, VECS[i].ord, 3'(i % 8));
      check(condCode == VECS[i].cc, $sformatf("R%0d cc vec%0d", VECS[i].req, i),
            condCode, VECS[i].cc);
      check(resultClass == VECS[i].cc, $sformatf("R7 class vec%0d", i),
            resultClass, VECS[i].cc);
      check(flagSnan == VECS[i].sn, $sformatf("R5 snan vec%0d", i),
            flagSnan, VECS[i].sn);
      check(flagInvCmp == VECS[i].ic, $sformatf("R6 invcmp vec%0d", i),
            flagInvCmp, VECS[i].ic);
      check(crWriteEn && crWriteIdx == 3'(i % 8), $sformatf("R8 write vec%0d", i),
            {crWriteEn, crWriteIdx}, {1'b1, 3'(i % 8)});
      @(negedge clk);
      check(!crWriteEn, $sformatf("R8 pulse end vec%0d", i), crWriteEn, 0);
    end

    // R7: hold while idle, inputs changing to NaNs in ordered mode
    issue(N1, P2, 1'b0, 3'd5);
    opA = SNAN; opB = QNAN; orderedMode = 1'b1;
    repeat (3) @(negedge clk);
    check(resultClass == 4'b1000 && condCode == 4'b1000, "R7 hold",
          {condCode, resultClass}, 8'h88);
    check(!flagSnan && !flagInvCmp && !crWriteEn, "R7 idle flags",
          {flagSnan, flagInvCmp, crWriteEn}, 0);
    check(crWriteIdx == 3'd5, "R8 idx hold", crWriteIdx, 5);

    // R8 back-to-back requests
    opA = P2; opB = P1; orderedMode = 1'b0; targetField = 3'd6; inValid = 1'b1;
    @(negedge clk);
    check(crWriteEn && crWriteIdx == 3'd6 && condCode == 4'b0100, "R8 b2b first",
          {crWriteEn, crWriteIdx, condCode}, {1'b1, 3'd6, 4'b0100});
    opA = QNAN; opB = P1; orderedMode = 1'b1; targetField = 3'd2;
    @(negedge clk);
    inValid = 1'b0;
    check(crWriteEn && crWriteIdx == 3'd2 && condCode == 4'b0001 && flagInvCmp,
          "R8 b2b second", {crWriteEn, crWriteIdx, condCode, flagInvCmp},
          {1'b1, 3'd2, 4'b0001, 1'b1});
    @(negedge clk);
    check(!crWriteEn && !flagInvCmp, "R6 flag one cycle", {crWriteEn, flagInvCmp}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule